// File: doc/BRIEF.md
# Latched One-of-Sixteen Decoder and Demultiplexer

This block converts a binary select code into a one-of-N output word. N is sixteen by default. The select code first passes through a holding stage that acts like a level-sensitive address latch. While the load control is high, the code goes straight through to the decoder. While the load control is low, the decoder keeps using the last code it captured. An active-low enable acts on the output stage only. When the enable is high, every output goes to its inactive level.

The enable is not latched. It can therefore carry a serial data stream, with the select code acting as the address. The addressed output then reproduces that stream, and the block works as a 1-to-N demultiplexer. The same enable serves as a chip select when several of these blocks share one address bus.

The block is built for a synchronous chip:
- The capture element is a flip-flop that is clock-enabled by the load control.
- A parameter selects one of two capture modes:
  - a transparent mode, where a bypass mux gives the latch-like pass-through;
  - a purely registered mode, which has one cycle of latency.
- A second parameter sets the output polarity.

Top module: `sel_latch_decoder`

## Requirements
- R1: In transparent capture mode, while `load_i` is high, the output decodes the present value of `sel_i` in the same cycle, with no clock edge in between.
- R2: While `load_i` is low, the output keeps decoding the code captured at the last rising clock edge at which `load_i` was high. Changes on `sel_i` have no effect. A code presented in the same cycle that `load_i` falls is not captured.
- R3: While `en_n_i` is high, every output bit is at its inactive level: all 0 for active-high polarity, all 1 for active-low polarity. This holds whatever the state of `load_i` and `sel_i`.
- R4: Code k addresses output bit k in straight binary, with `sel_i[SEL_W-1]` as the most significant bit. Code 0 drives `y_o[0]` and code 15 drives `y_o[15]`.
- R5: With active-high polarity (the default), an enabled block drives the addressed bit to 1 and all other bits to 0.
- R6: With active-low polarity, an enabled block drives the addressed bit to 0 and all other bits to 1.
- R7: As a demultiplexer, the addressed bit follows `en_n_i` in the same cycle. It is inverted for active-high polarity and unchanged for active-low polarity. All other bits stay inactive.
- R8: `en_n_i` is not captured. It acts on the outputs combinationally whatever the state of `load_i`, and toggling it never alters the stored code.
- R9: While the reset is asserted, and after it is released, the stored code is 0. With `load_i` low and the block enabled, bit 0 is the addressed output until the first load.
- R10: Whenever the block is enabled, exactly one output bit is at the active level.
- R11: In registered capture mode, the output decodes the code loaded at the previous rising clock edge at which `load_i` was high. The output therefore lags `sel_i` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_i | input | SEL_W (4) | Binary select code, also the demultiplexer address |
| load_i | input | 1 | High: pass and capture `sel_i`; low: hold the stored code |
| en_n_i | input | 1 | Active-low output enable, also the demultiplexer data input |
| y_o | output | 2**SEL_W (16) | Decoded output word |

## Verification
A full sweep of all sixteen codes, run with the load high, shows that each code reaches exactly its own bit under both polarities. The same sweep shows the transparent path reacting in the same cycle and the registered path reacting one cycle later. Hold sequences change the select input after the load falls, including a change in the same cycle as the fall. These show the difference between a correctly frozen code and a capture stage that leaks or captures late. A serial bit pattern on the enable is used with a fixed address; the addressed bit must follow it with the correct inversion while the other fifteen bits stay still. That pattern also separates a gated enable from one that was wrongly stored.

// File: rtl/latdec_pkg.sv
package latdec_pkg;

  // Output polarity: which level marks the addressed output.
  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } out_pol_e;

  // How the select code reaches the decoder.
  typedef enum logic {
    CAP_TRANSPARENT = 1'b0,
    CAP_REGISTERED  = 1'b1
  } cap_mode_e;

  localparam int unsigned DEF_SEL_W = 4;

endpackage

// File: rtl/sld_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module sld_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/sld_code_hold.sv
// Select-code capture stage: a clock-enabled register, plus an optional
// bypass so the stage behaves like a transparent latch while loading.
module sld_code_hold
  import latdec_pkg::*;
#(
  parameter int unsigned SEL_W = DEF_SEL_W,
  parameter cap_mode_e   CAP   = CAP_TRANSPARENT
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             load_i,
  output logic [SEL_W-1:0] code_o
);

  logic [SEL_W-1:0] code_q;
  logic             code_en;
  logic [SEL_W-1:0] code_d;

  // Next-state logic: load only while the load control is high.
  always_comb begin
    code_en = load_i;
    code_d  = sel_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  generate
    if (CAP == CAP_TRANSPARENT) begin : g_transp
      // Pass-through while loading, stored value while holding.
      assign code_o = load_i ? sel_i : code_q;
    end else begin : g_regd
      assign code_o = code_q;
    end
  endgenerate

endmodule

// File: rtl/sld_onehot.sv
// Binary code to one-hot word.
module sld_onehot #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned NOUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] code_i,
  output logic [NOUT-1:0]  hot_o
);

  generate
    for (genvar k = 0; k < NOUT; k++) begin : g_line
      assign hot_o[k] = (code_i == SEL_W'(k));
    end
  endgenerate

endmodule

// File: rtl/sld_out_gate.sv
// Enable gating and polarity selection of the decoded word.
module sld_out_gate
  import latdec_pkg::*;
#(
  parameter int unsigned NOUT = 16,
  parameter out_pol_e    POL  = POL_HIGH
) (
  input  logic [NOUT-1:0] hot_i,
  input  logic            en_n_i,
  output logic [NOUT-1:0] y_o
);

  logic [NOUT-1:0] gated;

  always_comb begin
    gated = hot_i & {NOUT{~en_n_i}};
  end

  generate
    if (POL == POL_HIGH) begin : g_hi
      assign y_o = gated;
    end else begin : g_lo
      assign y_o = ~gated;
    end
  endgenerate

endmodule

// File: rtl/sel_latch_decoder.sv
// Latched binary-to-one-of-N decoder and demultiplexer.
module sel_latch_decoder
  import latdec_pkg::*;
#(
  parameter int unsigned SEL_W = DEF_SEL_W,
  parameter out_pol_e    POL   = POL_HIGH,
  parameter cap_mode_e   CAP   = CAP_TRANSPARENT,
  localparam int unsigned NOUT = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             load_i,
  input  logic             en_n_i,
  output logic [NOUT-1:0]  y_o
);

  logic             rst_q_n;
  logic [SEL_W-1:0] code;
  logic [NOUT-1:0]  hot;

  sld_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sld_code_hold #(.SEL_W(SEL_W), .CAP(CAP)) u_hold (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .sel_i   (sel_i),
    .load_i  (load_i),
    .code_o  (code)
  );

  sld_onehot #(.SEL_W(SEL_W)) u_dec (
    .code_i (code),
    .hot_o  (hot)
  );

  sld_out_gate #(.NOUT(NOUT), .POL(POL)) u_gate (
    .hot_i  (hot),
    .en_n_i (en_n_i),
    .y_o    (y_o)
  );

endmodule

// File: rtl/sld_checker.sv
module sld_checker
  import latdec_pkg::*;
#(
  parameter int unsigned SEL_W = DEF_SEL_W,
  parameter out_pol_e    POL   = POL_HIGH,
  parameter cap_mode_e   CAP   = CAP_TRANSPARENT,
  localparam int unsigned NOUT = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic [SEL_W-1:0] sel_i,
  input logic             load_i,
  input logic             en_n_i,
  input logic [NOUT-1:0]  y_o
);

  logic [NOUT-1:0] act;
  assign act = (POL == POL_HIGH) ? y_o : ~y_o;

  // R3: a disabled block shows no active output
  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    en_n_i |-> (act == '0));

  // R10: exactly one active output while enabled
  a_r10_one_active: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en_n_i |-> ($countones(act) == 1));

  // R2: holding with the block enabled keeps the output still
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!load_i && $past(!load_i) && !en_n_i && $past(!en_n_i)) |-> $stable(y_o));

  generate
    if (CAP == CAP_TRANSPARENT) begin : g_chk_t
      // R1: pass-through follows the select input in the same cycle
      a_r1_follow: assert property (@(posedge clk) disable iff (!rst_q_n)
        (load_i && !en_n_i) |-> act[sel_i]);
    end else begin : g_chk_r
      // R11: registered mode shows the code loaded at the previous edge
      a_r11_lag: assert property (@(posedge clk) disable iff (!rst_q_n)
        ($past(rst_q_n) && $past(load_i) && !en_n_i) |-> act[$past(sel_i)]);
    end
  endgenerate

endmodule

bind sel_latch_decoder sld_checker #(.SEL_W(SEL_W), .POL(POL), .CAP(CAP)) chk_i (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .sel_i   (sel_i),
  .load_i  (load_i),
  .en_n_i  (en_n_i),
  .y_o     (y_o)
);

// File: tb/sel_latch_decoder_tb_top.sv
module sel_latch_decoder_tb_top;
  import latdec_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic        clk;
  logic        rst_n;
  logic [3:0]  sel;
  logic        load;
  logic        en_n;
  logic [15:0] y_hi;
  logic [15:0] y_lo;
  logic [15:0] y_rg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  sel_latch_decoder #(.SEL_W(4), .POL(POL_HIGH), .CAP(CAP_TRANSPARENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .load_i(load), .en_n_i(en_n), .y_o(y_hi));

  sel_latch_decoder #(.SEL_W(4), .POL(POL_LOW), .CAP(CAP_TRANSPARENT)) dut_lo_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .load_i(load), .en_n_i(en_n), .y_o(y_lo));

  sel_latch_decoder #(.SEL_W(4), .POL(POL_HIGH), .CAP(CAP_REGISTERED)) dut_rg_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .load_i(load), .en_n_i(en_n), .y_o(y_rg));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected active-high word for a code and enable.
  function automatic logic [15:0] exp_hi(input int code, input logic dis);
    logic [15:0] w;
    w = '0;
    if (!dis) w[code] = 1'b1;
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Advance one clock; return just after the falling edge, ready to drive.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load = 1'b0; en_n = 1'b0; sel = 4'd7;
    repeat (2) step();
    #1;
    check("R9 reset hi", y_hi, exp_hi(0, 1'b0));
    check("R9 R6 reset lo", y_lo, ~exp_hi(0, 1'b0));
    check("R9 reset reg", y_rg, exp_hi(0, 1'b0));
    rst_n = 1'b1;
    repeat (3) step();
    #1;
    check("R9 after release hi", y_hi, exp_hi(0, 1'b0));
    check("R9 after release reg", y_rg, exp_hi(0, 1'b0));
  endtask

  task automatic t_sweep();
    load = 1'b1; en_n = 1'b0;
    for (int c = 0; c < 16; c++) begin
      sel = 4'(c);
      #1;
      check($sformatf("R1 R4 R5 R10 code %0d hi", c), y_hi, exp_hi(c, 1'b0));
      check($sformatf("R6 R10 code %0d lo", c), y_lo, ~exp_hi(c, 1'b0));
      step();
      #1;
      check($sformatf("R11 code %0d reg", c), y_rg, exp_hi(c, 1'b0));
    end
  endtask

  task automatic t_hold();
    load = 1'b1; sel = 4'd5; en_n = 1'b0;
    step();
    load = 1'b0; sel = 4'd12;   // same cycle as the fall: not captured
    #1;
    check("R2 edge hi", y_hi, exp_hi(5, 1'b0));
    check("R2 edge reg", y_rg, exp_hi(5, 1'b0));
    for (int v = 0; v < 3; v++) begin
      sel = 4'(9 + v);
      step();
      #1;
      check("R2 hold hi", y_hi, exp_hi(5, 1'b0));
      check("R2 hold lo", y_lo, ~exp_hi(5, 1'b0));
      check("R2 hold reg", y_rg, exp_hi(5, 1'b0));
    end
  endtask

  task automatic t_disable();
    en_n = 1'b1; load = 1'b0; sel = 4'd2;
    #1;
    check("R3 off hold hi", y_hi, 16'h0000);
    check("R3 off hold lo", y_lo, 16'hffff);
    step();
    load = 1'b1; sel = 4'd14;
    #1;
    check("R3 off load hi", y_hi, 16'h0000);
    check("R3 off load lo", y_lo, 16'hffff);
    step();
    load = 1'b0; sel = 4'd1;
    step();
    step();
    en_n = 1'b0;
    #1;
    check("R8 enable immediate hi", y_hi, exp_hi(14, 1'b0));
    check("R8 code kept reg", y_rg, exp_hi(14, 1'b0));
  endtask

  task automatic t_demux();
    logic [7:0] pat;
    pat = 8'b1011_0010;
    load = 1'b1; sel = 4'd11; en_n = 1'b1;
    step();
    load = 1'b0; sel = 4'd3;
    for (int b = 0; b < 8; b++) begin
      en_n = pat[b];
      #1;
      check("R7 demux hi", y_hi, exp_hi(11, pat[b]));
      check("R7 demux lo", y_lo, ~exp_hi(11, pat[b]));
      step();
    end
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_disable();
    t_demux();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule